// File: doc/BRIEF.md
# Partition Power-Gate Register Unit

This block drives the power switches and isolation clamps of a set of independently gated power partitions (sixteen by default) from a small 32-bit register bus. Software flips the power state of one partition at a time by writing that partition's index together with a start flag. It reads back which partitions are fully powered and then releases each partition's isolation clamp with a one-hot mask write.

The power switch is modelled as a fixed settle time. After a partition's enable rises, a per-partition counter runs for `SETTLE_CYCLES` clock cycles before the partition counts as powered. Powering a partition off drops its enable and its powered flag at once and re-applies its clamp. Two partition indices (parameters `SWAP_A` and `SWAP_B`) have their clamp-release mask bits cross-wired: each of the two is released by the other's bit. Software must not ask for the state a partition already has, because the toggle command always inverts the current state.

Top module: `pgPartitionUnit`

## Requirements
- R1: Out of reset every partition has its power enable at 0, its clamp enable at 1, and its powered bit at 0.
- R2: A write to offset 0x30 with bit 8 set and an index in bits 7:0 below `NUM_PARTS` inverts that partition's power enable at the write edge and leaves every other partition untouched.
- R3: A write to offset 0x30 with bit 8 clear changes nothing.
- R4: A toggle write whose index is at or above `NUM_PARTS` changes nothing.
- R5: After a partition's power enable rises, its powered bit reads 0 for the first `SETTLE_CYCLES - 1` clock edges and 1 from the `SETTLE_CYCLES`-th edge on.
- R6: Powering a partition off (including during its settle time) clears its power enable and its powered bit at the same edge and forces its clamp enable back to 1.
- R7: A write to offset 0x34 with bit i set clears the clamp of partition i, for i other than `SWAP_A` and `SWAP_B`, only if that partition is powered. Other partitions' clamps are unchanged.
- R8: Partition `SWAP_A` (default 3) is released by mask bit `SWAP_B` (default 4), and partition `SWAP_B` by mask bit `SWAP_A`.
- R9: A clamp-release write for a partition that is not powered has no effect. Its clamp stays at 1 after the partition is powered.
- R10: Reading offset 0x38 returns the powered bits in bits `NUM_PARTS-1:0` and zero above. Every other offset reads zero, and writes to offsets other than 0x30 and 0x34 change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regAddr | input | ADDR_W | Register byte offset |
| regWrEn | input | 1 | Write strobe, one cycle per write |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Combinational read data for `regAddr` |
| pwrEn | output | NUM_PARTS | Power switch enable per partition |
| clampEn | output | NUM_PARTS | Isolation clamp enable per partition |

## Verification
The toggle path is driven with valid indices, with the start flag clear, with an index just past the last partition, and with writes to an undefined offset. These separate a real flip from ignored requests. Clamp-release masks are applied to powered partitions, to unpowered partitions, and to the two cross-wired positions before and after each of those partitions is powered, which exposes a missing or reversed swap. A directed test samples the powered bit on the edge before and on the edge where the settle count expires. A power-off during settling confirms that the count restarts.

// File: rtl/pgPkg.sv
package pgPkg;
  localparam int PG_MAX_PARTS = 32;
  localparam int PG_IDX_W     = 8;
  localparam int PG_START_BIT = 8;

  localparam logic [11:0] OFS_TOGGLE = 12'h030;
  localparam logic [11:0] OFS_UNCLAMP = 12'h034;
  localparam logic [11:0] OFS_STATUS = 12'h038;

  typedef struct packed {
    logic [PG_MAX_PARTS-1:0] toggle;
    logic [PG_MAX_PARTS-1:0] clampOff;
  } pgStrobes_t;
endpackage

// File: rtl/pgRegCtrl.sv
module pgRegCtrl
  import pgPkg::*;
#(
  parameter int NUM_PARTS = 16,
  parameter int ADDR_W    = 12,
  parameter int SWAP_A    = 3,
  parameter int SWAP_B    = 4
) (
  input  logic [ADDR_W-1:0]    regAddr,
  input  logic                 regWrEn,
  input  logic [31:0]          regWrData,
  input  logic [NUM_PARTS-1:0] statusVec,
  output pgStrobes_t           strobes,
  output logic [31:0]          regRdData
);
  logic toggleHit, unclampHit;
  int unsigned idxVal;

  assign toggleHit  = regWrEn && (regAddr == ADDR_W'(OFS_TOGGLE)) && regWrData[PG_START_BIT];
  assign unclampHit = regWrEn && (regAddr == ADDR_W'(OFS_UNCLAMP));
  assign idxVal     = 32'(regWrData[PG_IDX_W-1:0]);

  for (genvar i = 0; i < PG_MAX_PARTS; i++) begin : gStrobe
    if (i < NUM_PARTS) begin : gLive
      localparam int SRC = (i == SWAP_A) ? SWAP_B : ((i == SWAP_B) ? SWAP_A : i);
      assign strobes.toggle[i]   = toggleHit && (idxVal == i);
      assign strobes.clampOff[i] = unclampHit && regWrData[SRC];
    end else begin : gDead
      assign strobes.toggle[i]   = 1'b0;
      assign strobes.clampOff[i] = 1'b0;
    end
  end

  always_comb begin
    regRdData = '0;
    if (regAddr == ADDR_W'(OFS_STATUS)) regRdData[NUM_PARTS-1:0] = statusVec;
  end
endmodule

// File: rtl/pgPartDatapath.sv
module pgPartDatapath
  import pgPkg::*;
#(
  parameter int NUM_PARTS     = 16,
  parameter int SETTLE_CYCLES = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  pgStrobes_t           strobes,
  output logic [NUM_PARTS-1:0] pwrEn,
  output logic [NUM_PARTS-1:0] clampEn,
  output logic [NUM_PARTS-1:0] statusVec
);
  localparam int CNT_W = $clog2(SETTLE_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SETTLE_CYCLES - 1);

  for (genvar i = 0; i < NUM_PARTS; i++) begin : gPart
    logic [CNT_W-1:0] settleCnt;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        pwrEn[i]     <= 1'b0;
        statusVec[i] <= 1'b0;
        clampEn[i]   <= 1'b1;
        settleCnt    <= '0;
      end else if (strobes.toggle[i]) begin
        settleCnt <= '0;
        if (pwrEn[i]) begin
          pwrEn[i]     <= 1'b0;
          statusVec[i] <= 1'b0;
          clampEn[i]   <= 1'b1;
        end else begin
          pwrEn[i] <= 1'b1;
        end
      end else begin
        if (pwrEn[i] && !statusVec[i]) begin
          if (settleCnt == CNT_LAST) statusVec[i] <= 1'b1;
          else settleCnt <= settleCnt + 1'b1;
        end
        if (strobes.clampOff[i] && statusVec[i]) clampEn[i] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/pgPartitionUnit.sv
module pgPartitionUnit
  import pgPkg::*;
#(
  parameter int NUM_PARTS     = 16,
  parameter int ADDR_W        = 12,
  parameter int SETTLE_CYCLES = 8,
  parameter int SWAP_A        = 3,
  parameter int SWAP_B        = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [ADDR_W-1:0]    regAddr,
  input  logic                 regWrEn,
  input  logic [31:0]          regWrData,
  output logic [31:0]          regRdData,
  output logic [NUM_PARTS-1:0] pwrEn,
  output logic [NUM_PARTS-1:0] clampEn
);
  pgStrobes_t strobes;
  logic [NUM_PARTS-1:0] statusVec;

  pgRegCtrl #(
    .NUM_PARTS(NUM_PARTS), .ADDR_W(ADDR_W), .SWAP_A(SWAP_A), .SWAP_B(SWAP_B)
  ) uCtrl (
    .regAddr(regAddr), .regWrEn(regWrEn), .regWrData(regWrData),
    .statusVec(statusVec), .strobes(strobes), .regRdData(regRdData)
  );

  pgPartDatapath #(
    .NUM_PARTS(NUM_PARTS), .SETTLE_CYCLES(SETTLE_CYCLES)
  ) uPath (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .pwrEn(pwrEn), .clampEn(clampEn), .statusVec(statusVec)
  );
endmodule

// File: rtl/pgPartitionChk.sv
module pgPartitionChk
  import pgPkg::*;
#(
  parameter int NUM_PARTS = 16,
  parameter int ADDR_W    = 12
) (
  input logic                 clk,
  input logic                 rstN,
  input logic [ADDR_W-1:0]    regAddr,
  input logic                 regWrEn,
  input logic [31:0]          regWrData,
  input logic [31:0]          regRdData,
  input logic [NUM_PARTS-1:0] pwrEn,
  input logic [NUM_PARTS-1:0] clampEn,
  input logic [NUM_PARTS-1:0] statusVec
);
  logic isToggle, isUnclamp, idxOk;
  assign isToggle  = regWrEn && (regAddr == ADDR_W'(OFS_TOGGLE));
  assign isUnclamp = regWrEn && (regAddr == ADDR_W'(OFS_UNCLAMP));
  assign idxOk     = 32'(regWrData[PG_IDX_W-1:0]) < NUM_PARTS;

  // R6: an unpowered partition always has its clamp applied
  a_r6_clamp_when_off: assert property (@(posedge clk) disable iff (!rstN)
    ((~pwrEn & ~clampEn) == '0));

  // R5: powered bit only with the enable present
  a_r5_status_needs_en: assert property (@(posedge clk) disable iff (!rstN)
    ((statusVec & ~pwrEn) == '0));

  // R5: powered bit never rises in the same edge as the enable
  a_r5_no_instant_good: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((statusVec & ~$past(statusVec) & ~$past(pwrEn)) == '0));

  // R2: a valid toggle inverts exactly one enable bit
  a_r2_toggle_flips: assert property (@(posedge clk) disable iff (!rstN)
    (isToggle && regWrData[PG_START_BIT] && idxOk) |=> ($countones(pwrEn ^ $past(pwrEn)) == 1));

  // R3: start flag clear leaves the enables alone
  a_r3_no_start: assert property (@(posedge clk) disable iff (!rstN)
    (isToggle && !regWrData[PG_START_BIT]) |=> $stable(pwrEn));

  // R4: out-of-range index leaves the enables alone
  a_r4_bad_index: assert property (@(posedge clk) disable iff (!rstN)
    (isToggle && !idxOk) |=> $stable(pwrEn));

  // R9: clamp releases never occur outside a clamp-release write
  a_r9_release_source: assert property (@(posedge clk) disable iff (!rstN)
    !isUnclamp |=> ((~clampEn & $past(clampEn)) == '0));

  // R10: non-status offsets read zero
  a_r10_read_zero: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr != ADDR_W'(OFS_STATUS)) |-> (regRdData == '0));
endmodule

bind pgPartitionUnit pgPartitionChk #(.NUM_PARTS(NUM_PARTS), .ADDR_W(ADDR_W)) uChk (
  .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
  .regWrData(regWrData), .regRdData(regRdData), .pwrEn(pwrEn),
  .clampEn(clampEn), .statusVec(statusVec)
);

// File: tb/tb_pgPartitionUnit.sv
module tb_pgPartitionUnit;
  localparam int NP = 16;
  localparam int AW = 12;
  localparam int SETTLE = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [AW-1:0] regAddr = '0;
  logic regWrEn = 1'b0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic [NP-1:0] pwrEn, clampEn;
  int checks = 0;
  int failures = 0;

  always #10ns clk = ~clk;

  pgPartitionUnit #(.NUM_PARTS(NP), .ADDR_W(AW), .SETTLE_CYCLES(SETTLE),
                    .SWAP_A(3), .SWAP_B(4)) dut (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .pwrEn(pwrEn), .clampEn(clampEn));

  typedef struct packed {
    logic [11:0] addr;
    logic [31:0] data;
    logic [15:0] expPwr;
    logic [15:0] expClamp;
    logic [7:0]  req;
  } vec_t;

  localparam vec_t VECS [12] = '{
    '{12'h030, 32'h0000_0102, 16'h0004, 16'hFFFF, 8'd2},  // R2 power on 2
    '{12'h034, 32'h0000_0004, 16'h0004, 16'hFFFB, 8'd7},  // R7 release 2
    '{12'h030, 32'h0000_0103, 16'h000C, 16'hFFFB, 8'd2},  // R2 power on 3
    '{12'h034, 32'h0000_0008, 16'h000C, 16'hFFFB, 8'd8},  // R8 bit3 -> part 4 (off)
    '{12'h034, 32'h0000_0010, 16'h000C, 16'hFFF3, 8'd8},  // R8 bit4 -> part 3
    '{12'h030, 32'h0000_0003, 16'h000C, 16'hFFF3, 8'd3},  // R3 no start flag
    '{12'h030, 32'h0000_0110, 16'h000C, 16'hFFF3, 8'd4},  // R4 index 16
    '{12'h03C, 32'h0000_FFFF, 16'h000C, 16'hFFF3, 8'd10}, // R10 undefined offset
    '{12'h030, 32'h0000_0104, 16'h001C, 16'hFFF3, 8'd9},  // R9 part 4 still clamped
    '{12'h034, 32'h0000_0008, 16'h001C, 16'hFFE3, 8'd8},  // R8 bit3 -> part 4
    '{12'h030, 32'h0000_0102, 16'h0018, 16'hFFE7, 8'd6},  // R6 power off 2
    '{12'h034, 32'h0000_0004, 16'h0018, 16'hFFE7, 8'd9}   // R9 part 2 off
  };

  task automatic check(input int req, input logic [31:0] act, input logic [31:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL R%0d %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic doWrite(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0; regAddr = 12'h038;
  endtask

  task automatic finishRun();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #(20ns * 100000);
    failures++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    regAddr = 12'h038;
    // R1 reset state
    check(1, 32'(pwrEn), 32'h0, "reset pwrEn");
    check(1, 32'(clampEn), 32'h0000_FFFF, "reset clampEn");
    check(1, regRdData, 32'h0, "reset status");
    rstN = 1'b1;
    @(negedge clk);

    foreach (VECS[k]) begin
      doWrite(VECS[k].addr, VECS[k].data);
      repeat (SETTLE + 2) @(negedge clk);
      check(int'(VECS[k].req), 32'(pwrEn), 32'(VECS[k].expPwr), $sformatf("vec%0d pwrEn", k));
      check(int'(VECS[k].req), 32'(clampEn), 32'(VECS[k].expClamp), $sformatf("vec%0d clampEn", k));
      check(int'(VECS[k].req), regRdData, 32'(VECS[k].expPwr), $sformatf("vec%0d status", k));
    end

    // R5 settle edge timing on partition 15
    doWrite(12'h030, 32'h0000_010F);
    check(5, 32'(pwrEn[15]), 32'h1, "enable after write edge");
    repeat (SETTLE - 1) @(negedge clk);
    check(5, regRdData, 32'h0000_0018, "status one edge before settle");
    @(negedge clk);
    check(5, regRdData, 32'h0000_8018, "status at settle edge");

    // R10 other offsets read zero while status nonzero
    regAddr = 12'h030; #1ns;
    check(10, regRdData, 32'h0, "read toggle offset");
    regAddr = 12'h034; #1ns;
    check(10, regRdData, 32'h0, "read unclamp offset");
    regAddr = 12'h038;

    // R6 power off during settling restarts the count
    doWrite(12'h030, 32'h0000_0100);
    repeat (3) @(negedge clk);
    doWrite(12'h030, 32'h0000_0100);
    check(6, 32'(pwrEn[0]), 32'h0, "off during settle enable");
    check(6, 32'(clampEn[0]), 32'h1, "off during settle clamp");
    doWrite(12'h030, 32'h0000_0100);
    repeat (SETTLE - 1) @(negedge clk);
    check(5, 32'(regRdData[0]), 32'h0, "restarted count not early");
    @(negedge clk);
    check(5, 32'(regRdData[0]), 32'h1, "restarted count expires");

    // R7 release partition 0 leaves others clamped
    doWrite(12'h034, 32'h0000_8001);
    check(7, 32'(clampEn), 32'h0000_7FE6, "release 0 and 15");

    // R6 power off 15 re-clamps it
    doWrite(12'h030, 32'h0000_010F);
    check(6, 32'(clampEn[15]), 32'h1, "re-clamp on power off");
    check(6, 32'(regRdData[15]), 32'h0, "status cleared at off edge");

    finishRun();
  end
endmodule